// File: doc/BRIEF.md
# Safe Status Eight-Digit Display Driver

This block drives a bank of eight common-anode seven-segment digits that show the state of a code-locked safe. The bank is scanned: one digit is lit at a time, and a free-running refresh counter moves the lit digit along so that, fast enough, all eight appear lit together.

Digits 0 to 3 spell a status word chosen by a two-bit status code: LOCK, OPEN, an error word (E, r, r, blank), or nothing at all. Digits 4 to 7 show progress through a four-digit code entry. Position p (digit 4+p) shows the hex value of its confirmed digit once the entry index has moved past it. At the entry index it shows the live switch value, and beyond the entry index it shows a single middle bar. The safe controller supplies the status code, the captured digits, the entry index and the switch value. The driver only presents them.

Top module: `safe_disp_top`

## Requirements
- R1: While reset is asserted, and after its release until the first refresh terminal count, every digit enable is high (off) and every segment line is high (off).
- R2: At most one bit of `digEnN` is low in any cycle.
- R3: The lit digit goes 0, 1, ... 7 and then back to 0. Each digit stays lit for exactly REFRESH_DIV clock cycles. Digit k is lit when `digEnN` equals the inverse of 1 shifted left by k.
- R4: With status code 0, digits 0 to 3 show L, O, C, K. The active-high patterns (bit 0 = segment a ... bit 6 = segment g) are 0x38, 0x3F, 0x39, 0x76, and `segN` carries their inverse.
- R5: With status code 1, digits 0 to 3 show O, P, E, N. The patterns are 0x3F, 0x73, 0x79, 0x37.
- R6: With status code 2, digits 0 to 3 show E, r, r, blank (0x79, 0x50, 0x50, 0x00). With status code 3, all four are blank.
- R7: Entry position p reads the nibble `capDigits[4p+3:4p]`. A position below `entryIdx` shows the hex glyph of that nibble, with 0..F = 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R8: The position equal to `entryIdx` shows the hex glyph of `liveSw`. A change of `liveSw` shows on `segN` in the same cycle while that position is lit.
- R9: A position above `entryIdx` shows only segment g (active-high 0x40, so `segN` = 0x3F).
- R10: When `entryIdx` is 4 or more, all four entry positions show their captured nibbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| statusCode | input | 2 | 0 lock, 1 open, 2 error, 3 blank |
| capDigits | input | 16 | Four captured code nibbles, position 0 in bits 3:0 |
| entryIdx | input | 3 | Position being entered, 0..3; 4..7 means all four confirmed |
| liveSw | input | 4 | Current switch value |
| segN | output | 7 | Active-low segments, bit 0 = a ... bit 6 = g |
| digEnN | output | 8 | Active-low digit enables, bit k = digit k |

## Verification
The assertions assume that the inputs change only just after a rising edge and that the refresh strobe is the only event that moves the scan. They place no constraint on the input values, because every code, index and nibble value has a defined glyph. The stimulus applies each new input set one time unit after a clock edge, during the last digit of a sweep. It covers all four status codes, entry indices 0, 1, 2, 3, 4 and 7, and a switch change made while the live position is lit.

// File: rtl/safe_disp_pkg.sv
package safe_disp_pkg;
  localparam int DIGITS   = 8;
  localparam int WORD_LEN = 4;
  localparam int NIB_W    = 4;
  localparam int SEG_W    = 7;
  localparam int IDX_W    = $clog2(DIGITS);
  localparam int ENTRY_W  = $clog2(WORD_LEN) + 1;

  // control -> datapath strobes
  typedef struct packed {
    logic advance;
  } scan_strobe_t;

  // active-high glyphs, bit0 = a .. bit6 = g
  localparam logic [SEG_W-1:0] G_BLANK = 7'h00;
  localparam logic [SEG_W-1:0] G_BAR   = 7'h40;
  localparam logic [SEG_W-1:0] G_L     = 7'h38;
  localparam logic [SEG_W-1:0] G_O     = 7'h3F;
  localparam logic [SEG_W-1:0] G_C     = 7'h39;
  localparam logic [SEG_W-1:0] G_K     = 7'h76;
  localparam logic [SEG_W-1:0] G_P     = 7'h73;
  localparam logic [SEG_W-1:0] G_E     = 7'h79;
  localparam logic [SEG_W-1:0] G_N     = 7'h37;
  localparam logic [SEG_W-1:0] G_R     = 7'h50;

  // words packed with letter 0 in the low slot
  localparam logic [WORD_LEN*SEG_W-1:0] WORD_LOCK = {G_K, G_C, G_O, G_L};
  localparam logic [WORD_LEN*SEG_W-1:0] WORD_OPEN = {G_N, G_E, G_P, G_O};
  localparam logic [WORD_LEN*SEG_W-1:0] WORD_ERR  = {G_BLANK, G_R, G_R, G_E};

  function automatic logic [SEG_W-1:0] hexGlyph(input logic [NIB_W-1:0] nib);
    case (nib)
      4'h0: hexGlyph = 7'h3F;
      4'h1: hexGlyph = 7'h06;
      4'h2: hexGlyph = 7'h5B;
      4'h3: hexGlyph = 7'h4F;
      4'h4: hexGlyph = 7'h66;
      4'h5: hexGlyph = 7'h6D;
      4'h6: hexGlyph = 7'h7D;
      4'h7: hexGlyph = 7'h07;
      4'h8: hexGlyph = 7'h7F;
      4'h9: hexGlyph = 7'h6F;
      4'hA: hexGlyph = 7'h77;
      4'hB: hexGlyph = 7'h7C;
      4'hC: hexGlyph = 7'h39;
      4'hD: hexGlyph = 7'h5E;
      4'hE: hexGlyph = 7'h79;
      default: hexGlyph = 7'h71;
    endcase
  endfunction

  function automatic logic [SEG_W-1:0] wordGlyph(input logic [1:0] code, input int slot);
    case (code)
      2'd0:    wordGlyph = WORD_LOCK[slot*SEG_W +: SEG_W];
      2'd1:    wordGlyph = WORD_OPEN[slot*SEG_W +: SEG_W];
      2'd2:    wordGlyph = WORD_ERR[slot*SEG_W +: SEG_W];
      default: wordGlyph = G_BLANK;
    endcase
  endfunction
endpackage

// File: rtl/safe_disp_ctrl.sv
module safe_disp_ctrl
  import safe_disp_pkg::*;
#(
  parameter int REFRESH_DIV = 50000
) (
  input  logic         clk,
  input  logic         rst_n,
  output scan_strobe_t strobe
);
  localparam int CW = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFRESH_DIV - 1);

  logic [CW-1:0] refreshCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  refreshCnt <= '0;
    else if (refreshCnt == LAST) refreshCnt <= '0;
    else                         refreshCnt <= refreshCnt + 1'b1;
  end

  assign strobe.advance = (refreshCnt == LAST);

  // R3: the counter never runs past its terminal value
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    refreshCnt <= LAST);
endmodule

// File: rtl/safe_disp_dp.sv
module safe_disp_dp
  import safe_disp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  scan_strobe_t              strobe,
  input  logic [1:0]                statusCode,
  input  logic [WORD_LEN*NIB_W-1:0] capDigits,
  input  logic [ENTRY_W-1:0]        entryIdx,
  input  logic [NIB_W-1:0]          liveSw,
  output logic [SEG_W-1:0]          segN,
  output logic [DIGITS-1:0]         digEnN
);
  logic [IDX_W-1:0] scanIdx;
  logic             scanOn;
  logic [SEG_W-1:0] glyphHi [DIGITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scanIdx <= '0;
      scanOn  <= 1'b0;
    end else if (strobe.advance) begin
      if (!scanOn) begin
        scanOn  <= 1'b1;
        scanIdx <= '0;
      end else if (scanIdx == IDX_W'(DIGITS - 1)) begin
        scanIdx <= '0;
      end else begin
        scanIdx <= scanIdx + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < WORD_LEN; g++) begin : gStatus
    assign glyphHi[g] = wordGlyph(statusCode, g);
  end

  for (genvar p = 0; p < WORD_LEN; p++) begin : gEntry
    always_comb begin
      if (ENTRY_W'(p) < entryIdx)       glyphHi[WORD_LEN+p] = hexGlyph(capDigits[p*NIB_W +: NIB_W]);
      else if (ENTRY_W'(p) == entryIdx) glyphHi[WORD_LEN+p] = hexGlyph(liveSw);
      else                              glyphHi[WORD_LEN+p] = G_BAR;
    end
  end

  always_comb begin
    segN   = scanOn ? ~glyphHi[scanIdx] : '1;
    digEnN = scanOn ? ~(DIGITS'(1) << scanIdx) : '1;
  end

  // R2: never more than one digit enabled
  a_r2_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~digEnN));

  // R3: enables move only on the refresh strobe
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance |=> $stable(digEnN));

  // R3: once scanning, each strobe moves the lit digit up by one, wrapping
  a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && digEnN != '1) |=>
      digEnN == {$past(digEnN[DIGITS-2:0]), $past(digEnN[DIGITS-1])});

  // R1: segments are dark whenever no digit is enabled
  a_r1_dark_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (digEnN == '1) |-> (segN == '1));
endmodule

// File: rtl/safe_disp_top.sv
module safe_disp_top #(
  parameter int REFRESH_DIV = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  statusCode,
  input  logic [15:0] capDigits,
  input  logic [2:0]  entryIdx,
  input  logic [3:0]  liveSw,
  output logic [6:0]  segN,
  output logic [7:0]  digEnN
);
  import safe_disp_pkg::*;

  scan_strobe_t strobe;

  safe_disp_ctrl #(.REFRESH_DIV(REFRESH_DIV)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe)
  );

  safe_disp_dp dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .statusCode (statusCode),
    .capDigits  (capDigits),
    .entryIdx   (entryIdx),
    .liveSw     (liveSw),
    .segN       (segN),
    .digEnN     (digEnN)
  );
endmodule

// File: tb/safe_disp_top_tb_top.sv
module safe_disp_top_tb_top;
  localparam int DIV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  statusCode = '0;
  logic [15:0] capDigits = '0;
  logic [2:0]  entryIdx = '0;
  logic [3:0]  liveSw = '0;
  logic [6:0]  segN;
  logic [7:0]  digEnN;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] en;
    logic [6:0] seg;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  safe_disp_top #(.REFRESH_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .statusCode(statusCode), .capDigits(capDigits),
    .entryIdx(entryIdx), .liveSw(liveSw), .segN(segN), .digEnN(digEnN)
  );

  function automatic logic [6:0] hexPat(input logic [3:0] v);
    logic [6:0] t;
    case (v)
      4'h0: t = 7'h3F; 4'h1: t = 7'h06; 4'h2: t = 7'h5B; 4'h3: t = 7'h4F;
      4'h4: t = 7'h66; 4'h5: t = 7'h6D; 4'h6: t = 7'h7D; 4'h7: t = 7'h07;
      4'h8: t = 7'h7F; 4'h9: t = 7'h6F; 4'hA: t = 7'h77; 4'hB: t = 7'h7C;
      4'hC: t = 7'h39; 4'hD: t = 7'h5E; 4'hE: t = 7'h79; default: t = 7'h71;
    endcase
    return t;
  endfunction

  function automatic logic [6:0] expPat(input logic [1:0] st, input logic [15:0] cap,
                                        input logic [2:0] idx, input logic [3:0] live, input int d);
    int p;
    if (d < 4) begin
      case (st)
        2'd0: return (d == 0) ? 7'h38 : (d == 1) ? 7'h3F : (d == 2) ? 7'h39 : 7'h76;
        2'd1: return (d == 0) ? 7'h3F : (d == 1) ? 7'h73 : (d == 2) ? 7'h79 : 7'h37;
        2'd2: return (d == 0) ? 7'h79 : (d == 3) ? 7'h00 : 7'h50;
        default: return 7'h00;
      endcase
    end
    p = d - 4;
    if (p < int'(idx))  return hexPat(cap[p*4 +: 4]);
    if (p == int'(idx)) return hexPat(live);
    return 7'h40;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: pop expected items as each digit lights, and time each digit
  logic [7:0] prevEn = 8'hFF;
  int holdCnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (digEnN !== prevEn) begin
        if (prevEn !== 8'hFF) check("R3 hold", 16'(holdCnt), 16'(DIV));
        if (sb.size() > 0) begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " enable"}, {8'h0, digEnN}, {8'h0, e.en});
          check({e.tag, " segments"}, {9'h0, segN}, {9'h0, e.seg});
        end
        prevEn  = digEnN;
        holdCnt = 1;
      end else begin
        holdCnt++;
      end
    end
  end

  bit firstRun = 1'b1;
  task automatic runPattern(input logic [1:0] st, input logic [15:0] cap, input logic [2:0] idx,
                            input logic [3:0] live, input string tagS, input string tagE);
    if (!firstRun) begin
      do @(negedge clk); while (digEnN !== 8'h7F);
      @(posedge clk); #1;
    end
    statusCode = st; capDigits = cap; entryIdx = idx; liveSw = live;
    for (int d = 0; d < 8; d++) begin
      exp_t e;
      e.en  = ~(8'h01 << d);
      e.seg = ~expPat(st, cap, idx, live, d);
      e.tag = (d < 4) ? tagS : tagE;
      sb.push_back(e);
    end
    if (firstRun) begin
      firstRun = 1'b0;
      return;
    end
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset enables", {8'h0, digEnN}, 16'h00FF);
    check("R1 reset segments", {9'h0, segN}, 16'h007F);
    // R4 R8 R9: lock word, entering position 0
    runPattern(2'd0, 16'h0000, 3'd0, 4'hA, "R4", "R8/R9");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 dark before first strobe", {8'h0, digEnN}, 16'h00FF);
    while (sb.size() > 0) @(negedge clk);
    // R5 R7 R8 R9
    runPattern(2'd1, 16'h0093, 3'd2, 4'h5, "R5", "R7/R8/R9");
    // R6 R7
    runPattern(2'd2, 16'h0FED, 3'd3, 4'h1, "R6", "R7/R8");
    // R6 blank word, R10 all captured
    runPattern(2'd3, 16'h8B2C, 3'd4, 4'h0, "R6 blank", "R10");
    runPattern(2'd0, 16'h4761, 3'd7, 4'hF, "R4", "R10 idx7");
    // R8: live switch change while the live position is lit
    runPattern(2'd1, 16'h00A0, 3'd1, 4'h2, "R5", "R7/R8/R9");
    do @(negedge clk); while (digEnN !== 8'hDF);
    @(posedge clk); #1 liveSw = 4'h7;
    @(negedge clk);
    check("R8 live follow", {9'h0, segN}, {9'h0, ~7'h07});
    check("R2 single enable", {8'h0, digEnN}, 16'h00DF);
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule